// File: doc/BRIEF.md
# Hardware Cursor Overlay Mixer

This block places a 32x32 hardware cursor on top of the pixel stream of a display controller. For each active pixel it receives the beam coordinates and the background colour. When the beam lies inside the cursor window, it combines the matching cursor texel with the background. Otherwise the background passes through. The mixed pixel appears one clock later, and the valid and sync strobes are delayed by the same clock.

The cursor image is held in a local pattern memory of 1024 sixteen-bit words, loaded through a plain write port. A small register port sets the following:
- the cursor start coordinates,
- a 12-bit image base address,
- the enable and doubling bits,
- a global disable flag.

All writes go into a shadow copy first. They reach the mixer only while the vertical sync input is high, so a cursor move never tears a frame.

Top module: `hwc_mixer`

## Requirements
- R1: While reset is held and directly after it, `pix_o`, `valid_o`, `hsync_o`, `vsync_o`, `pos_rdata` and `cur_base_o` are all zero, and the cursor is disabled.
- R2: `valid_o`, `hsync_o` and `vsync_o` equal `pix_valid_i`, `hsync_i` and `vsync_i` from one clock earlier. `pix_o` is the result for the beam inputs of that same earlier clock.
- R3: When the beam is outside the cursor window, or the cursor is not enabled, `pix_o` equals `bg_pixel` unchanged. Without doubling, the window covers offsets 0..31 from the start position on both axes.
- R4: The pattern word for texel column c and row r sits at pattern address r*32+c. Inside the window, a texel whose bit 15 is 1 replaces the background. In narrow mode (`wide_mode`=0) the output is {9'b0, texel[14:0]}.
- R5: A texel whose bit 15 is 0 is XOR-ed with the background. In narrow mode the output is {9'b0, texel[14:0] ^ bg[14:0]}.
- R6: In wide mode (`wide_mode`=1), the three 5-bit channels (red 14:10, green 9:5, blue 4:0) are each widened to 8 bits as {c, c[4:2]}. The 24-bit result then replaces the background or is XOR-ed with it, following bit 15.
- R7: Register select 0 is the position word: X in bits 11:0, Y in bits 27:16. `pos_rdata` returns the last written value with every other bit zero.
- R8: Select 1 bits 6:0 give base bits 11:5, and bit 7 is ignored. Select 2 bits 7:3 give base bits 4:0, bit 0 is enable and bit 1 is doubling. `cur_base_o` shows the applied base.
- R9: Select 3 bit 5 is a disable flag. While it is applied, no cursor pixel is drawn, whatever the enable bit says.
- R10: No cursor pixel is drawn when start X is at or beyond `h_disp`, or start Y is at or beyond `v_disp`.
- R11: With doubling on, the window spans offsets 0..63 on both axes. The texel index is the offset shifted right by one, so each texel covers a 2x2 screen area.
- R12: Register writes leave the mixer and `cur_base_o` unchanged until a clock in which `vsync_i` is high. The shadowed values apply from the next clock on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 position, 1 base high, 2 base low/control, 3 disable byte) |
| reg_wdata | input | 32 | Register write data |
| pos_rdata | output | 32 | Position register readback |
| cur_base_o | output | 12 | Applied cursor base address |
| pat_we | input | 1 | Pattern memory write strobe |
| pat_addr | input | 10 | Pattern word address (row*32+column) |
| pat_wdata | input | 16 | Pattern texel data |
| h_disp | input | 12 | Horizontal display width |
| v_disp | input | 12 | Vertical display end |
| wide_mode | input | 1 | 1 selects 24-bit output mixing, 0 selects 15-bit |
| pix_valid_i | input | 1 | Active pixel strobe |
| hsync_i | input | 1 | Horizontal sync in |
| vsync_i | input | 1 | Vertical sync in; also applies shadowed registers |
| beam_x | input | 12 | Current beam column |
| beam_y | input | 12 | Current beam row |
| bg_pixel | input | 24 | Background pixel |
| pix_o | output | 24 | Mixed pixel, one clock later |
| valid_o | output | 1 | Delayed valid |
| hsync_o | output | 1 | Delayed horizontal sync |
| vsync_o | output | 1 | Delayed vertical sync |

## Verification
The assertions assume the following about the inputs:
- `pix_valid_i` and the sync inputs are low while reset is asserted.
- The pattern memory is not written in the same clock as a pixel whose result is checked.

The bench keeps to both: it holds every strobe at zero during reset, and it finishes all pattern loading before any pixel is driven. Beam coordinates are drawn at random in a band around the cursor, so both edges of the window are crossed often. Register writes are made only while the pixel strobe is low.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
   parameter int CW        = 12;
   parameter int BASE_HI_W = 7;
   parameter int BASE_LO_W = 5;
   localparam int BASE_W   = BASE_HI_W + BASE_LO_W;

   typedef enum logic [1:0] {
      SEL_POS     = 2'd0,
      SEL_BASE_HI = 2'd1,
      SEL_BASE_LO = 2'd2,
      SEL_CTL     = 2'd3
   } hwc_sel_e;

   typedef struct packed {
      logic [CW-1:0]     x;
      logic [CW-1:0]     y;
      logic [BASE_W-1:0] base;
      logic              en;
      logic              dbl;
      logic              dis;
   } hwc_cfg_t;
endpackage

// File: rtl/hwc_regs.sv
module hwc_regs
   import hwc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  hwc_sel_e    sel,
   input  logic [31:0] wdata,
   input  logic        frame_sync,
   output logic [31:0] pos_rdata,
   output hwc_cfg_t    act
);
   localparam int Y_LSB = 16;

   if (CW > 16) begin : g_bad_cw
      $error("coordinate width must fit a half word");
   end

   hwc_cfg_t shadow;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow <= '0;
         act    <= '0;
      end else begin
         if (wr_en) begin
            case (sel)
               SEL_POS: begin
                  shadow.x <= wdata[CW-1:0];
                  shadow.y <= wdata[Y_LSB +: CW];
               end
               SEL_BASE_HI: shadow.base[BASE_W-1 -: BASE_HI_W] <= wdata[BASE_HI_W-1:0];
               SEL_BASE_LO: begin
                  shadow.base[BASE_LO_W-1:0] <= wdata[7 -: BASE_LO_W];
                  shadow.en  <= wdata[0];
                  shadow.dbl <= wdata[1];
               end
               default: shadow.dis <= wdata[5];
            endcase
         end
         if (frame_sync) act <= shadow;
      end
   end

   always_comb begin
      pos_rdata              = '0;
      pos_rdata[CW-1:0]      = shadow.x;
      pos_rdata[Y_LSB +: CW] = shadow.y;
   end

   // R12: applied settings only move on a frame boundary
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_sync |=> $stable(act));
endmodule

// File: rtl/hwc_window.sv
module hwc_window
   import hwc_pkg::*;
#(
   parameter int CUR_DIM = 32
) (
   input  hwc_cfg_t         cfg,
   input  logic [CW-1:0]    beam_x,
   input  logic [CW-1:0]    beam_y,
   input  logic [CW-1:0]    h_disp,
   input  logic [CW-1:0]    v_disp,
   output logic             hit,
   output logic [2*$clog2(CUR_DIM)-1:0] tex_addr
);
   localparam int IDX_W = $clog2(CUR_DIM);

   if ((1 << IDX_W) != CUR_DIM) begin : g_bad_dim
      $error("cursor size must be a power of two");
   end
   if (2 * CUR_DIM >= (1 << CW)) begin : g_bad_span
      $error("doubled cursor must fit the coordinate range");
   end

   logic [CW-1:0]    dx, dy, span;
   logic             in_x, in_y, onscreen;
   logic [IDX_W-1:0] tx, ty;

   always_comb begin
      span     = cfg.dbl ? CW'(2 * CUR_DIM) : CW'(CUR_DIM);
      dx       = beam_x - cfg.x;
      dy       = beam_y - cfg.y;
      in_x     = (beam_x >= cfg.x) && (dx < span);
      in_y     = (beam_y >= cfg.y) && (dy < span);
      onscreen = (cfg.x < h_disp) && (cfg.y < v_disp);
      hit      = cfg.en && !cfg.dis && onscreen && in_x && in_y;
      tx       = cfg.dbl ? dx[IDX_W:1] : dx[IDX_W-1:0];
      ty       = cfg.dbl ? dy[IDX_W:1] : dy[IDX_W-1:0];
      tex_addr = {ty, tx};
   end
endmodule

// File: rtl/hwc_pattern_mem.sv
module hwc_pattern_mem #(
   parameter int DEPTH = 1024,
   parameter int W     = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/hwc_mix.sv
module hwc_mix #(
   parameter int PIX_W = 24,
   parameter int CH_W  = 5,
   parameter int OUT_W = 8,
   localparam int NCH  = 3,
   localparam int NW   = NCH * CH_W
) (
   input  logic [NW:0]      texel,
   input  logic [PIX_W-1:0] bg,
   input  logic             wide,
   output logic [PIX_W-1:0] mixed
);
   if (PIX_W != NCH * OUT_W) begin : g_bad_pix
      $error("pixel width must hold three widened channels");
   end
   if (OUT_W <= CH_W || OUT_W > 2 * CH_W) begin : g_bad_ch
      $error("channel widening must add between one and CH_W bits");
   end

   logic [PIX_W-1:0] wide_src;

   for (genvar c = 0; c < NCH; c++) begin : g_widen
      assign wide_src[c*OUT_W +: OUT_W] =
         {texel[c*CH_W +: CH_W], texel[c*CH_W + CH_W - 1 -: OUT_W - CH_W]};
   end

   logic          rep;
   logic [NW-1:0] narrow;

   always_comb begin
      rep    = texel[NW];
      narrow = rep ? texel[NW-1:0] : (texel[NW-1:0] ^ bg[NW-1:0]);
      if (wide) mixed = rep ? wide_src : (wide_src ^ bg);
      else      mixed = {{(PIX_W-NW){1'b0}}, narrow};
   end
endmodule

// File: rtl/hwc_mixer.sv
module hwc_mixer
   import hwc_pkg::*;
#(
   parameter int CUR_DIM  = 32,
   parameter int PIX_W    = 24,
   parameter int TEX_W    = 16,
   localparam int IDX_W   = $clog2(CUR_DIM),
   localparam int PAT_AW  = 2 * IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [1:0]        reg_sel,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       pos_rdata,
   output logic [BASE_W-1:0] cur_base_o,
   input  logic              pat_we,
   input  logic [PAT_AW-1:0] pat_addr,
   input  logic [TEX_W-1:0]  pat_wdata,
   input  logic [CW-1:0]     h_disp,
   input  logic [CW-1:0]     v_disp,
   input  logic              wide_mode,
   input  logic              pix_valid_i,
   input  logic              hsync_i,
   input  logic              vsync_i,
   input  logic [CW-1:0]     beam_x,
   input  logic [CW-1:0]     beam_y,
   input  logic [PIX_W-1:0]  bg_pixel,
   output logic [PIX_W-1:0]  pix_o,
   output logic              valid_o,
   output logic              hsync_o,
   output logic              vsync_o
);
   if (TEX_W != 16) begin : g_bad_tex
      $error("texel must be one mode bit plus three 5-bit channels");
   end

   hwc_cfg_t          cfg;
   logic              hit_c;
   logic [PAT_AW-1:0] tex_addr;
   logic [TEX_W-1:0]  texel;
   logic [PIX_W-1:0]  mixed;
   logic              started;

   hwc_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr_en),
      .sel        (hwc_sel_e'(reg_sel)),
      .wdata      (reg_wdata),
      .frame_sync (vsync_i),
      .pos_rdata  (pos_rdata),
      .act        (cfg)
   );

   hwc_window #(.CUR_DIM(CUR_DIM)) u_win (
      .cfg      (cfg),
      .beam_x   (beam_x),
      .beam_y   (beam_y),
      .h_disp   (h_disp),
      .v_disp   (v_disp),
      .hit      (hit_c),
      .tex_addr (tex_addr)
   );

   hwc_pattern_mem #(.DEPTH(CUR_DIM * CUR_DIM), .W(TEX_W)) u_pat (
      .clk   (clk),
      .we    (pat_we),
      .waddr (pat_addr),
      .wdata (pat_wdata),
      .raddr (tex_addr),
      .rdata (texel)
   );

   hwc_mix #(.PIX_W(PIX_W)) u_mix (
      .texel (texel),
      .bg    (bg_pixel),
      .wide  (wide_mode),
      .mixed (mixed)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pix_o   <= '0;
         valid_o <= 1'b0;
         hsync_o <= 1'b0;
         vsync_o <= 1'b0;
         started <= 1'b0;
      end else begin
         pix_o   <= hit_c ? mixed : bg_pixel;
         valid_o <= pix_valid_i;
         hsync_o <= hsync_i;
         vsync_o <= vsync_i;
         started <= 1'b1;
      end
   end

   assign cur_base_o = cfg.base;

   // R2: strobes delayed by exactly one clock
   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> (valid_o == $past(pix_valid_i) && hsync_o == $past(hsync_i)
                   && vsync_o == $past(vsync_i)));

   // R3: background passes untouched outside the window
   p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid_i && !hit_c) |=> (pix_o == $past(bg_pixel)));

   // R9: disable flag beats the enable bit
   p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.dis |-> !hit_c);

   // R10: offscreen start suppresses the cursor
   p_offscreen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.x >= h_disp || cfg.y >= v_disp) |-> !hit_c);
endmodule

// File: tb/hwc_mixer_test.sv
module hwc_mixer_test;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic        reg_wr_en;
   logic [1:0]  reg_sel;
   logic [31:0] reg_wdata;
   logic [31:0] pos_rdata;
   logic [11:0] cur_base_o;
   logic        pat_we;
   logic [9:0]  pat_addr;
   logic [15:0] pat_wdata;
   logic [11:0] h_disp, v_disp;
   logic        wide_mode;
   logic        pix_valid_i, hsync_i, vsync_i;
   logic [11:0] beam_x, beam_y;
   logic [23:0] bg_pixel;
   logic [23:0] pix_o;
   logic        valid_o, hsync_o, vsync_o;

   hwc_mixer uut (.*);

   int n_run = 0, n_fail = 0;
   logic [15:0] tex [1024];
   int sh_x, sh_y, ac_x, ac_y;
   logic [6:0] sh_hi, ac_hi;
   logic [4:0] sh_lo, ac_lo;
   logic sh_en, sh_dbl, sh_dis, ac_en, ac_dbl, ac_dis;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] exp_pix(int x, int y, logic [23:0] bg, logic wd);
      int span = ac_dbl ? 64 : 32;
      int dx = x - ac_x, dy = y - ac_y, tx, ty;
      logic [15:0] t;
      logic [23:0] w;
      logic [14:0] n;
      if (!ac_en || ac_dis || ac_x >= int'(h_disp) || ac_y >= int'(v_disp) ||
          dx < 0 || dy < 0 || dx >= span || dy >= span) return bg;
      tx = ac_dbl ? dx / 2 : dx;
      ty = ac_dbl ? dy / 2 : dy;
      t = tex[ty*32 + tx];
      if (wd) begin
         w = {t[14:10], t[14:12], t[9:5], t[9:7], t[4:0], t[4:2]};
         return t[15] ? w : (w ^ bg);
      end
      n = t[15] ? t[14:0] : (t[14:0] ^ bg[14:0]);
      return {9'b0, n};
   endfunction

   task automatic pix(string req, int x, int y, logic [23:0] bg, logic vld, logic hs, logic vs);
      logic [23:0] e;
      @(negedge clk);
      beam_x = 12'(x); beam_y = 12'(y); bg_pixel = bg;
      pix_valid_i = vld; hsync_i = hs; vsync_i = vs;
      e = exp_pix(x, y, bg, wide_mode);
      @(posedge clk); #1;
      if (vs) begin
         ac_x = sh_x; ac_y = sh_y; ac_hi = sh_hi; ac_lo = sh_lo;
         ac_en = sh_en; ac_dbl = sh_dbl; ac_dis = sh_dis;
      end
      check(req, {8'h0, pix_o}, {8'h0, e});
      check("R2 strobes", {29'h0, valid_o, hsync_o, vsync_o}, {29'h0, vld, hs, vs});
      @(negedge clk);
      pix_valid_i = 1'b0; hsync_i = 1'b0; vsync_i = 1'b0;
   endtask

   task automatic wr(logic [1:0] sel, logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
      case (sel)
         2'd0: begin sh_x = int'(d[11:0]); sh_y = int'(d[27:16]); end
         2'd1: sh_hi = d[6:0];
         2'd2: begin sh_lo = d[7:3]; sh_en = d[0]; sh_dbl = d[1]; end
         default: sh_dis = d[5];
      endcase
   endtask

   task automatic pw(int a, logic [15:0] d);
      @(negedge clk);
      pat_we = 1'b1; pat_addr = 10'(a); pat_wdata = d;
      @(negedge clk);
      pat_we = 1'b0;
      tex[a] = d;
   endtask

   task automatic commit();
      pix("R12 commit cycle", 0, 0, 24'h0, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic rand_band(string req, int n);
      for (int i = 0; i < n; i++) begin
         int x = ac_x - 8 + int'($urandom_range(0, 80));
         int y = ac_y - 8 + int'($urandom_range(0, 80));
         pix(req, x, y, 24'($urandom), 1'b1, 1'($urandom_range(0, 1)), 1'b0);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; reg_wr_en = 1'b0; reg_sel = '0; reg_wdata = '0;
      pat_we = 1'b0; pat_addr = '0; pat_wdata = '0;
      h_disp = 12'd640; v_disp = 12'd480; wide_mode = 1'b0;
      pix_valid_i = 1'b0; hsync_i = 1'b0; vsync_i = 1'b0;
      beam_x = '0; beam_y = '0; bg_pixel = '0;
      sh_x = 0; sh_y = 0; ac_x = 0; ac_y = 0; sh_hi = '0; ac_hi = '0;
      sh_lo = '0; ac_lo = '0; sh_en = 0; sh_dbl = 0; sh_dis = 0;
      ac_en = 0; ac_dbl = 0; ac_dis = 0;
      repeat (5) @(posedge clk);
      #1;
      check("R1 reset outputs", {pix_o, 5'b0, valid_o, hsync_o, vsync_o}, 32'h0);
      check("R1 reset pos", pos_rdata, 32'h0);
      check("R1 reset base", {20'h0, cur_base_o}, 32'h0);
      @(negedge clk); rst_n = 1'b1;

      for (int i = 0; i < 1024; i++) pw(i, 16'($urandom));
      pw(0, 16'h8000 | 16'h1234);
      pw(1, 16'h0abc);
      pw(2, 16'h801f);

      // R1: cursor off after reset, pixel passes through
      pix("R1 disabled after reset", 3, 3, 24'h123456, 1'b1, 1'b0, 1'b0);

      // R7: packing and ignored bits
      wr(2'd0, {4'hf, 12'd50, 4'ha, 12'd100});
      check("R7 readback", pos_rdata, {4'h0, 12'd50, 4'h0, 12'd100});
      wr(2'd1, 32'h80 | 32'h25);
      wr(2'd2, {24'h0, 5'h13, 3'b001});
      // R12: nothing applied yet
      check("R12 base before vsync", {20'h0, cur_base_o}, 32'h0);
      pix("R12 no overlay before vsync", 100, 50, 24'h00aaaa, 1'b1, 1'b0, 1'b0);
      commit();
      check("R8 base", {20'h0, cur_base_o}, {20'h0, 7'h25, 5'h13});

      // R4/R5 directed, narrow
      pix("R4 replace", 100, 50, 24'hffffff, 1'b1, 1'b0, 1'b0);
      pix("R5 xor", 101, 50, 24'h00ffff, 1'b1, 1'b0, 1'b0);
      // R3 window edges
      pix("R3 last column", 131, 81, 24'h111111, 1'b1, 1'b0, 1'b0);
      pix("R3 past column", 132, 50, 24'h222222, 1'b1, 1'b0, 1'b0);
      pix("R3 before start", 99, 50, 24'h333333, 1'b1, 1'b0, 1'b0);
      rand_band("R3/R4/R5 narrow random", 400);

      // R6 wide mode
      wide_mode = 1'b1;
      pix("R6 widened replace", 102, 50, 24'h abcdef, 1'b1, 1'b0, 1'b0);
      check("R6 widened value", {8'h0, pix_o}, 32'h0000ff);
      rand_band("R6 wide random", 400);

      // R11 doubling
      wr(2'd2, {24'h0, 5'h13, 3'b011});
      commit();
      pix("R11 doubled 2x2 texel", 101, 51, 24'h0f0f0f, 1'b1, 1'b0, 1'b0);
      pix("R11 doubled far edge", 163, 113, 24'h0f0f0f, 1'b1, 1'b0, 1'b0);
      pix("R11 doubled outside", 164, 60, 24'h0f0f0f, 1'b1, 1'b0, 1'b0);
      rand_band("R11 doubled random", 400);
      wide_mode = 1'b0;
      rand_band("R11 doubled narrow random", 200);

      // R9 disable flag
      wr(2'd3, 32'h20);
      commit();
      pix("R9 disabled inside", 110, 60, 24'h445566, 1'b1, 1'b0, 1'b0);
      rand_band("R9 disabled random", 100);
      wr(2'd3, 32'h00);
      commit();

      // R10 offscreen
      wr(2'd0, {4'h0, 12'd20, 4'h0, 12'd640});
      commit();
      pix("R10 x at width", 645, 25, 24'h778899, 1'b1, 1'b0, 1'b0);
      wr(2'd0, {4'h0, 12'd480, 4'h0, 12'd20});
      commit();
      pix("R10 y at end", 25, 485, 24'h778899, 1'b1, 1'b0, 1'b0);
      wr(2'd0, {4'h0, 12'd479, 4'h0, 12'd639});
      commit();
      pix("R10 last onscreen start", 639, 479, 24'h778899, 1'b1, 1'b0, 1'b0);

      finish_run();
   end
endmodule